// File: doc/BRIEF.md
# SPI Register Access Slave Frontend

This block lets an external SPI master read and write an 8-bit-wide internal register space. Every transfer opens with a short header. The header carries an address and a 3-bit command. In the most common form the header is two bytes and the address is 13 bits. When the command is the extension code, a third header byte follows. That byte adds the three top address bits and a second command. While the master shifts the header in, the slave shifts three bytes of interrupt request status back to it, one byte per header byte. This lets the master poll pending events as a side effect of every access.

After the header, the block turns data bytes into single-cycle strobes on a simple register port. The port has an address, write data, a write strobe, a read strobe and read data. The address steps up by one after each access, so a burst of any length reaches consecutive registers. The SPI pins are sampled by the system clock, so the SPI clock must run well below it.

Top module: `spi_regport_slave`

## Requirements
- R1: After synchronous reset, `miso` is 0, `bus_rd` and `bus_wr` are low, and `bus_addr` is 0.
- R2: The bus uses SPI mode 0 with the MSB first. Header byte 0 returns `irq_status[7:0]` on `miso`. Header byte 1 returns `irq_status[15:8]`.
- R3: The first header byte carries address bits 12..5. Header byte 1 carries address bits 4..0 in bits 7..3 and the command in bits 2..0. The command codes are 000 none, 010 read, 011 read with wait byte, 100 write and 110 extension. In a 2-byte header, address bits 15..13 are 0.
- R4: When the command in byte 1 is 110, a third header byte follows. Its bits 7..5 become address bits 15..13 and its bits 2..0 are the command, coded as in R3. `miso` returns `irq_status[23:16]` during this byte.
- R5: For a read (010), data byte i on `miso` is the register at address A+i. Each byte is fetched with one `bus_rd` pulse, and the data is taken one cycle after the pulse.
- R6: For a read with wait byte (011), the first byte after the header is a dummy byte that returns 0. The following bytes return the registers at A, A+1, and so on.
- R7: For a write (100), each complete data byte produces exactly one `bus_wr` pulse. The pulse carries that byte to address A+i.
- R8: Commands 000, 001, 101 and 111 cause no `bus_rd` or `bus_wr`, and `miso` is 0 in their data phase. The same holds for 110 when it appears in the third header byte.
- R9: Deasserting `cs_n` aborts the transfer. A partly received byte is discarded with no access, and the next transfer starts again at header byte 0.
- R10: Each status byte is captured at the start of its header byte. A change of `irq_status` in the middle of a byte does not alter the bits being sent.
- R11: `bus_rd` and `bus_wr` never pulse together. `bus_addr` advances by one in the cycle after each pulse, wrapping at 16 bits.
- R12: `miso` is 0 throughout the data phase of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | SPI clock from master (idle low) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master |
| irq_status | input | 24 | Interrupt status bytes; [7:0] sent first |
| bus_addr | output | 16 | Register port address |
| bus_wdata | output | 8 | Register port write data |
| bus_wr | output | 1 | Write strobe, one cycle |
| bus_rd | output | 1 | Read strobe, one cycle |
| bus_rdata | input | 8 | Read data, valid the cycle after `bus_rd` |

## Verification
The hardest case to reach from the ports is the second command byte. To get there, the master must first send the extension code in byte 1. The stimulus therefore sweeps every code in the third byte, including a second extension code, and runs each sweep at addresses whose top bits are set, so both address wrap and command decode are covered. A status change in the middle of a byte is forced by a parallel process. That process rewrites `irq_status` a few SPI bits into header byte 0. The bench then checks that byte 0 keeps the old value while byte 1 shows the new one. Aborts are produced by raising `cs_n` four bits into a write data byte.

// File: rtl/spi_regport_pkg.sv
// Package: shared constants and types for the SPI register access frontend.
package spi_regport_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;

    localparam logic [2:0] CMD_READ      = 3'b010;
    localparam logic [2:0] CMD_READ_WAIT = 3'b011;
    localparam logic [2:0] CMD_WRITE     = 3'b100;
    localparam logic [2:0] CMD_EXTEND    = 3'b110;

    typedef enum logic [2:0] {ST_H0, ST_H1, ST_H2, ST_DUMMY, ST_DATA} hdr_state_t;
    typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR} op_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings the asynchronous SPI pins into the system clock domain and
// derives one-cycle edge pulses for the clock and chip select.
// Assumes: SCLK half period is several system clocks long.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_start,
    output logic cs_active,
    output logic mosi_s
);
    logic [STAGES-1:0] sck_sr, cs_sr, dat_sr;
    logic              sck_prev, cs_prev;

    // Purpose: synchroniser chains plus previous-value registers for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sr   <= '0;
            cs_sr    <= '1;
            dat_sr   <= '0;
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_sr   <= {sck_sr[STAGES-2:0], sclk};
            cs_sr    <= {cs_sr[STAGES-2:0], cs_n};
            dat_sr   <= {dat_sr[STAGES-2:0], mosi};
            sck_prev <= sck_sr[STAGES-1];
            cs_prev  <= cs_sr[STAGES-1];
        end
    end

    assign sclk_rise = sck_sr[STAGES-1] & ~sck_prev;
    assign sclk_fall = ~sck_sr[STAGES-1] & sck_prev;
    assign cs_start  = ~cs_sr[STAGES-1] & cs_prev;
    assign cs_active = ~cs_sr[STAGES-1];
    assign mosi_s    = dat_sr[STAGES-1];
endmodule

// File: rtl/spi_byte_shifter.sv
// Module: spi_byte_shifter
// Assembles received bits into bytes (sampled on SCLK rise, MSB first)
// and shifts the transmit byte out on SCLK fall. The fall right after a
// byte boundary does not shift, because a new byte is loaded there instead.
// Assumes: tx_load arrives before that fall.
module spi_byte_shifter
    import spi_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              miso
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              skip_q;

    // Purpose: receive shift, bit count, byte-done pulse and skip flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
            skip_q    <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!active) begin
                bit_cnt <= '0;
                skip_q  <= 1'b0;
            end else if (rise) begin
                rx_sh   <= {rx_sh[DATA_W-3:0], din};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh, din};
                    skip_q    <= 1'b1;
                end
            end else if (fall) begin
                skip_q <= 1'b0;
            end
        end
    end

    // Purpose: transmit register, loaded by the controller, shifted on fall.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sh <= '0;
        else if (tx_load)
            tx_sh <= tx_data;
        else if (active && fall && !skip_q)
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
    end

    assign miso = active & tx_sh[DATA_W-1];

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);
    a_r10_miso_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fall && !tx_load) |=> (!active || $stable(miso)));
endmodule

// File: rtl/spi_access_ctrl.sv
// Module: spi_access_ctrl
// Decodes the header bytes and selects the status byte or read data to
// send. Issues register port strobes and advances the address after each
// access. Assumes: read data is valid the cycle after bus_rd, and bytes
// arrive many cycles apart.
module spi_access_ctrl
    import spi_regport_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                cs_start,
    input  logic                byte_done,
    input  logic [DATA_W-1:0]   rx_byte,
    input  logic [3*DATA_W-1:0] irq_status,
    input  logic [DATA_W-1:0]   bus_rdata,
    output logic                tx_load,
    output logic [DATA_W-1:0]   tx_data,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic                bus_wr,
    output logic                bus_rd
);
    hdr_state_t        state_q;
    op_t               op_q;
    logic [DATA_W-1:0] hdr_hi_q;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q, wr_q, rd_d1_q;
    logic [2:0]        cmd;

    assign cmd = rx_byte[2:0];

    // Purpose: choose what is loaded into the transmit register and when.
    always_comb begin
        tx_load = 1'b0;
        tx_data = '0;
        if (cs_start) begin
            tx_load = 1'b1;
            tx_data = irq_status[DATA_W-1:0];
        end else if (byte_done && active) begin
            tx_load = 1'b1;
            if (state_q == ST_H0)
                tx_data = irq_status[2*DATA_W-1:DATA_W];
            else if (state_q == ST_H1 && cmd == CMD_EXTEND)
                tx_data = irq_status[3*DATA_W-1:2*DATA_W];
        end else if (rd_d1_q && active) begin
            tx_load = 1'b1;
            tx_data = bus_rdata;
        end
    end

    // Purpose: header state machine, access strobes and address counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_H0;
            op_q      <= OP_NONE;
            hdr_hi_q  <= '0;
            addr_q    <= '0;
            bus_wdata <= '0;
            rd_q      <= 1'b0;
            wr_q      <= 1'b0;
            rd_d1_q   <= 1'b0;
        end else begin
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            rd_d1_q <= rd_q;
            if (rd_q || wr_q)
                addr_q <= addr_q + 1'b1;
            if (!active) begin
                state_q <= ST_H0;
                op_q    <= OP_NONE;
            end else if (byte_done) begin
                case (state_q)
                    ST_H0: begin
                        hdr_hi_q <= rx_byte;
                        state_q  <= ST_H1;
                    end
                    ST_H1, ST_H2: begin
                        if (state_q == ST_H1)
                            addr_q <= {3'b000, hdr_hi_q, rx_byte[7:3]};
                        else
                            addr_q <= {rx_byte[7:5], addr_q[ADDR_W-4:0]};
                        if (state_q == ST_H1 && cmd == CMD_EXTEND) begin
                            state_q <= ST_H2;
                        end else begin
                            state_q <= ST_DATA;
                            case (cmd)
                                CMD_READ:      begin op_q <= OP_RD; rd_q <= 1'b1; end
                                CMD_READ_WAIT: begin op_q <= OP_RD; state_q <= ST_DUMMY; end
                                CMD_WRITE:     op_q <= OP_WR;
                                default:       op_q <= OP_NONE;
                            endcase
                        end
                    end
                    ST_DUMMY: begin
                        rd_q    <= 1'b1;
                        state_q <= ST_DATA;
                    end
                    default: begin
                        if (op_q == OP_RD)
                            rd_q <= 1'b1;
                        if (op_q == OP_WR) begin
                            wr_q      <= 1'b1;
                            bus_wdata <= rx_byte;
                        end
                    end
                endcase
            end
        end
    end

    assign bus_addr = addr_q;
    assign bus_rd   = rd_q;
    assign bus_wr   = wr_q;

    a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_q && wr_q));
    a_r11_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q || wr_q) |=> addr_q == $past(addr_q) + 16'd1);
    a_r8_no_access_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_NONE && state_q == ST_DATA) |-> !rd_q && !wr_q);
    a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !rd_q && !wr_q);
endmodule

// File: rtl/spi_regport_slave.sv
// Module: spi_regport_slave (top)
// An SPI mode 0 slave. It decodes a 2- or 3-byte address/command header,
// returns interrupt status during the header, and then reads or writes
// bytes on a simple register port with automatic address increment.
// Assumes: the SCLK half period is at least 8 system clock cycles.
module spi_regport_slave
    import spi_regport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                cs_n,
    input  logic                mosi,
    output logic                miso,
    input  logic [3*DATA_W-1:0] irq_status,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_wdata,
    output logic                bus_wr,
    output logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_rdata
);
    logic              rise, fall, cs_start, active, din, byte_done, tx_load;
    logic [DATA_W-1:0] rx_byte, tx_data;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .sclk_rise(rise), .sclk_fall(fall), .cs_start(cs_start),
        .cs_active(active), .mosi_s(din)
    );

    spi_byte_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .active(active), .rise(rise), .fall(fall),
        .din(din), .tx_load(tx_load), .tx_data(tx_data),
        .byte_done(byte_done), .rx_byte(rx_byte), .miso(miso)
    );

    spi_access_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .active(active), .cs_start(cs_start),
        .byte_done(byte_done), .rx_byte(rx_byte), .irq_status(irq_status),
        .bus_rdata(bus_rdata), .tx_load(tx_load), .tx_data(tx_data),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd)
    );
endmodule

// File: tb/spi_regport_slave_tb.sv
module spi_regport_slave_tb;
    localparam int HP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso, bus_wr, bus_rd;
    logic [23:0] irq_status = 24'h0;
    logic [15:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;

    int errors = 0, checks = 0;
    int wr_cnt = 0, rd_cnt = 0, both_cnt = 0;
    logic [15:0] wr_addr_log [0:15];
    logic [7:0]  wr_data_log [0:15];
    logic [15:0] rd_addr_log [0:15];
    logic [7:0]  tx_b [0:15];
    logic [7:0]  rx_b [0:15];

    always #10 clk = ~clk;

    spi_regport_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .irq_status(irq_status), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] regval(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h3C;
    endfunction

    // Register model: one-cycle read latency.
    always_ff @(posedge clk) if (bus_rd) bus_rdata <= regval(bus_addr);

    // Bus monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (bus_wr && bus_rd) both_cnt++;
        if (bus_wr) begin
            if (wr_cnt < 16) begin wr_addr_log[wr_cnt] = bus_addr; wr_data_log[wr_cnt] = bus_wdata; end
            wr_cnt++;
        end
        if (bus_rd) begin
            if (rd_cnt < 16) rd_addr_log[rd_cnt] = bus_addr;
            rd_cnt++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_hp(input int n);
        repeat (n * HP) @(negedge clk);
    endtask

    // Runs one transfer; the last byte is cut after last_bits bits.
    task automatic xfer(input int nbytes, input int last_bits);
        wr_cnt = 0; rd_cnt = 0;
        @(negedge clk); cs_n = 1'b0;
        wait_hp(1);
        for (int i = 0; i < nbytes; i++) begin
            rx_b[i] = 8'h00;
            for (int b = 0; b < 8; b++) begin
                if (i == nbytes - 1 && b >= last_bits) break;
                mosi = tx_b[i][7-b];
                wait_hp(1);
                rx_b[i][7-b] = miso;
                sclk = 1'b1;
                wait_hp(1);
                sclk = 1'b0;
            end
        end
        wait_hp(1);
        cs_n = 1'b1;
        wait_hp(3);
    endtask

    // Builds a header, runs nd data bytes and checks against the spec.
    task automatic run_case(input logic [15:0] addr, input bit three, input logic [2:0] c0,
                            input logic [2:0] c1, input int nd, input int seed);
        int h; int kind; int total; int dstart;
        logic [15:0] a; bit ok;
        irq_status = {8'(seed) ^ 8'hC3, 8'(seed) + 8'h11, ~8'(seed)};
        h = three ? 3 : 2;
        kind = three ? int'(c1) : int'(c0);
        a = three ? addr : {3'b000, addr[12:0]};
        tx_b[0] = addr[12:5];
        tx_b[1] = {addr[4:0], three ? 3'b110 : c0};
        tx_b[2] = {addr[15:13], 2'b00, c1};
        dstart = (kind == 3) ? h + 1 : h;
        total = dstart + nd;
        for (int i = h; i < total; i++) tx_b[i] = (kind == 3 && i == h) ? 8'hFF : 8'hA0 + 8'(i + seed);
        xfer(total, 8);
        chk(rx_b[0] == irq_status[7:0], "R2 status byte0", rx_b[0], irq_status[7:0]);
        chk(rx_b[1] == irq_status[15:8], "R2 status byte1", rx_b[1], irq_status[15:8]);
        if (three) chk(rx_b[2] == irq_status[23:16], "R4 status byte2", rx_b[2], irq_status[23:16]);
        chk(both_cnt == 0, "R11 strobe overlap", both_cnt, 0);
        if (kind == 2 || kind == 3) begin
            if (kind == 3) chk(rx_b[h] == 8'h00, "R6 dummy byte", rx_b[h], 0);
            ok = 1;
            for (int i = 0; i < nd; i++) if (rx_b[dstart+i] != regval(a + 16'(i))) ok = 0;
            chk(ok, kind == 3 ? "R6 wait read data" : "R5 read data", rx_b[dstart], regval(a));
            ok = (rd_cnt >= nd);
            for (int i = 0; i < nd && i < 16; i++) if (rd_addr_log[i] != a + 16'(i)) ok = 0;
            chk(ok, "R3 R5 read addresses", rd_cnt > 0 ? rd_addr_log[0] : 0, a);
            chk(wr_cnt == 0, "R5 no write in read", wr_cnt, 0);
        end else if (kind == 4) begin
            ok = (wr_cnt == nd);
            for (int i = 0; i < nd; i++)
                if (wr_addr_log[i] != a + 16'(i) || wr_data_log[i] != tx_b[h+i]) ok = 0;
            chk(ok, "R7 R3 write log", wr_cnt > 0 ? wr_addr_log[0] : 0, a);
            chk(rd_cnt == 0, "R7 no read in write", rd_cnt, 0);
            chk(bus_addr == a + 16'(nd), "R11 address after burst", bus_addr, a + 16'(nd));
            ok = 1;
            for (int i = h; i < total; i++) if (rx_b[i] != 8'h00) ok = 0;
            chk(ok, "R12 miso low in write", rx_b[h], 0);
        end else begin
            chk(rd_cnt == 0 && wr_cnt == 0, "R8 no access", rd_cnt + wr_cnt, 0);
            ok = 1;
            for (int i = h; i < total; i++) if (rx_b[i] != 8'h00) ok = 0;
            chk(ok, "R8 miso low", rx_b[h], 0);
        end
    endtask

    initial begin
        logic [15:0] addrs2 [0:2];
        logic [15:0] addrs3 [0:1];
        addrs2[0] = 16'h0000; addrs2[1] = 16'h1ABC; addrs2[2] = 16'hFFFF;
        addrs3[0] = 16'hE123; addrs3[1] = 16'hFFFE;
        repeat (5) @(negedge clk);
        chk(miso == 0 && !bus_rd && !bus_wr && bus_addr == 16'h0, "R1 reset state",
            {miso, bus_rd, bus_wr}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Sweep every 2-byte command code over several addresses.
        for (int ai = 0; ai < 3; ai++)
            for (int c = 0; c < 8; c++)
                if (c != 6) run_case(addrs2[ai], 1'b0, 3'(c), 3'b000, 3, ai * 8 + c);
        // Sweep every second command code after the extension code.
        for (int ai = 0; ai < 2; ai++)
            for (int c = 0; c < 8; c++)
                run_case(addrs3[ai], 1'b1, 3'b110, 3'(c), 3, 40 + ai * 8 + c);

        // R9: abort in the middle of a write data byte.
        tx_b[0] = 8'h12; tx_b[1] = {5'h03, 3'b100}; tx_b[2] = 8'h77;
        xfer(3, 4);
        chk(wr_cnt == 0, "R9 partial byte discarded", wr_cnt, 0);
        run_case(16'h0345, 1'b0, 3'b010, 3'b000, 2, 99);

        // R10: status changes during header byte 0.
        irq_status = 24'h5A_3C_A5;
        tx_b[0] = 8'h00; tx_b[1] = 8'h00;
        fork
            xfer(2, 8);
            begin wait_hp(7); irq_status = 24'h00_96_0F; end
        join
        chk(rx_b[0] == 8'hA5, "R10 byte0 held", rx_b[0], 8'hA5);
        chk(rx_b[1] == 8'h96, "R10 byte1 latched later", rx_b[1], 8'h96);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule